// File: doc/BRIEF.md
# UART Register Front End with Sticky Flags and Interrupt

This block is the processor-facing side of a UART. It decodes word-indexed register writes, provides a combinational read path, and holds the configuration that the serial shifter and baud generator need. It also keeps two 16-entry character queues. The receive queue is filled by a strobe from the shifter. The transmit queue is loaded by writes to the data register and drained by a take strobe from the transmitter.

Software changes the status flags only through a write-only command register. That register has an independent set bit and an independent clear bit for every flag. The same register carries the commands that pull a received character into the data register and that flush either queue.

Transmit-ready follows a programmable occupancy threshold. Receive-ready waits a programmable number of bit times after a character lands in an empty receive queue. A single interrupt line is the OR of every flag gated by its enable bit. A force-break control holds the serial output low.

Top module: `uart_regif`

## Requirements
- R1: Word index 1 (control) reads back bits [25:0] of the last value written to it, and word index 2 (baud) reads back bits [15:0]; unused upper bits read 0. Index 3 (action), index 5, index 6 and index 7 read 0, and writes to indices 5 to 7 have no effect.
- R2: The configuration outputs follow the control register, with word length in bits [8:6], parity enable in bit 9, even parity in bit 10, two stop bits in bit 11 and handshake enable in bit 12. baudMant follows baud bits [11:0] and baudExp follows baud bits [15:12].
- R3: While control bit 13 is set, txSerialOut is 0; otherwise it equals txSerialIn.
- R4: Received characters queue in arrival order. Writing action bit 10 moves the oldest one into the data register (index 0, bits [7:0]). Status bits [10:6] hold the receive queue count.
- R5: A pull when the receive queue is empty leaves the count at 0 and the data register at its last value.
- R6: A receive strobe while 16 characters are stored sets overrun (status bit 2) and discards the character.
- R7: A receive strobe with rxFrameErr sets status bit 4, and one with rxParityErr sets status bit 5. A rxBreak pulse sets status bit 3. All of these flags are sticky.
- R8: Action bits [4:0] clear receive-ready, overrun, break, framing and parity; bits [9:5] set the same flags in the same order. When set and clear of one flag arrive in a single write, the set wins.
- R9: Receive-ready (status bit 0) rises on the clock edge after the count of bitTick pulses reaches the delay in control bits [21:14]. Counting starts when a character enters an empty receive queue; with a delay of 0 the flag rises on the edge after the push.
- R10: A write to index 0 enqueues wrData[7:0] for transmit. txChar and txValid present the oldest entry, and txTake removes it. Status bits [15:11] hold the transmit count. A write when 16 entries are held is dropped.
- R11: Transmit-ready (status bit 1) is set on every cycle in which the transmit count is at most the threshold in control bits [25:22]. Action bit 13 clears the flag and action bit 14 sets it.
- R12: Action bit 11 empties the receive queue and action bit 12 empties the transmit queue.
- R13: irq is high when any flag is set together with its enable bit. The enable bits are control bit 0 for receive-ready, bit 1 for overrun, bit 2 for break, bit 3 for framing, bit 4 for parity and bit 5 for transmit-ready.
- R14: During reset, status, data, control and baud read 0 and irq is 0. One cycle after reset, transmit-ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Word index of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for regAddr |
| rxStrobe | input | 1 | Received character valid |
| rxChar | input | 8 | Received character |
| rxFrameErr | input | 1 | Framing error on the received character |
| rxParityErr | input | 1 | Parity error on the received character |
| rxBreak | input | 1 | Break condition seen |
| bitTick | input | 1 | One pulse per bit time |
| txTake | input | 1 | Transmitter consumes the head character |
| txChar | output | 8 | Head of the transmit queue |
| txValid | output | 1 | Transmit queue not empty |
| txSerialIn | input | 1 | Serial line from the shifter |
| txSerialOut | output | 1 | Serial line after the break override |
| wordLen | output | 3 | Word length field |
| parityEn | output | 1 | Parity enable |
| parityEven | output | 1 | Even parity select |
| twoStop | output | 1 | Two stop bits |
| handshakeEn | output | 1 | Hardware handshake enable |
| baudMant | output | 12 | Baud mantissa |
| baudExp | output | 4 | Baud exponent |
| irq | output | 1 | Interrupt request |

## Verification
The bench probes the receive-ready delay one bit time short of the limit and then exactly at it. A timer that fires early or late shows the flag at the wrong point. It writes set and clear bits for the same flags in one command, so a design that lets the clear win leaves those flags low. It sends a seventeenth character into a full receive queue and then drains the queue. A design that overwrites instead of dropping returns that extra character or loses overrun. It also pulls from an empty queue, clears transmit-ready while the count sits above the threshold, and overfills the transmit queue. Wrong bookkeeping in any of these shows up as a wrong count, a changed data value or a flag that does not hold.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RegData   = 3'd0,
    RegCtrl   = 3'd1,
    RegBaud   = 3'd2,
    RegAction = 3'd3,
    RegStatus = 3'd4
  } regSel_e;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic rxPull;
    logic rxClear;
    logic txClear;
    logic txPush;
  } dpCmd_t;

  // status flag positions
  localparam int FL_RRDY = 0;
  localparam int FL_TRDY = 1;
  localparam int FL_OE   = 2;
  localparam int FL_BRK  = 3;
  localparam int FL_FE   = 4;
  localparam int FL_PE   = 5;
  localparam int NFLAGS  = 6;
endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push & ~full & ~clr;
  assign doPop  = pop & ~empty & ~clr;
  assign head   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clr |=> count == CW'(DEPTH)); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !clr |=> count == '0); // R5
endmodule

// File: rtl/uart_regif_dp.sv
module uart_regif_dp
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxStrobe,
  input  logic [DATA_W-1:0] rxChar,
  input  logic              txTake,
  output logic [CW-1:0]     rxCount,
  output logic [CW-1:0]     txCount,
  output logic [DATA_W-1:0] rxData,
  output logic              rxPushEmpty,
  output logic              rxDrop,
  output logic [DATA_W-1:0] txChar,
  output logic              txValid
);
  logic [DATA_W-1:0] rxHead;
  logic rxFull, rxEmpty, txFull, txEmpty;

  uart_regif_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rst_n(rst_n), .push(rxStrobe), .pop(cmd.rxPull),
    .clr(cmd.rxClear), .din(rxChar), .head(rxHead), .count(rxCount),
    .full(rxFull), .empty(rxEmpty));

  uart_regif_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rst_n(rst_n), .push(cmd.txPush), .pop(txTake),
    .clr(cmd.txClear), .din(txWrData), .head(txChar), .count(txCount),
    .full(txFull), .empty(txEmpty));

  assign txValid     = ~txEmpty;
  assign rxPushEmpty = rxStrobe & rxEmpty & ~cmd.rxClear;
  assign rxDrop      = rxStrobe & rxFull;

  always_ff @(posedge clk) begin
    if (!rst_n)                       rxData <= '0;
    else if (cmd.rxPull && !rxEmpty)  rxData <= rxHead;
  end

  AST_PULL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rxPull && !rxEmpty |=> rxData == $past(rxHead)); // R4
  AST_EMPTY_PULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rxPull && rxEmpty |=> $stable(rxData)); // R5
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    txFull && cmd.txPush && !txTake && !cmd.txClear |=> txCount == CW'(DEPTH)); // R10
endmodule

// File: rtl/uart_regif_ctrl.sv
module uart_regif_ctrl
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              rxStrobe,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  input  logic              rxBreak,
  input  logic              bitTick,
  input  logic              rxPushEmpty,
  input  logic              rxDrop,
  input  logic [CW-1:0]     rxCount,
  input  logic [CW-1:0]     txCount,
  input  logic [DATA_W-1:0] rxData,
  output dpCmd_t            cmd,
  output logic [2:0]        wordLen,
  output logic              parityEn,
  output logic              parityEven,
  output logic              twoStop,
  output logic              handshakeEn,
  output logic              forceBreak,
  output logic [11:0]       baudMant,
  output logic [3:0]        baudExp,
  output logic              irq
);
  logic [25:0] ctlReg;
  logic [15:0] baudReg;
  logic [NFLAGS-1:0] flags, clrV, setV, hwSet, enV;
  logic [7:0] rdyDelay, dlyCnt;
  logic [3:0] txThresh;
  logic dlyActive, rdyFire, txBelow, actWr;
  logic unusedWr;

  assign unusedWr = ^wrData[31:26];
  assign actWr    = wrEn && regAddr == RegAction;

  assign wordLen     = ctlReg[8:6];
  assign parityEn    = ctlReg[9];
  assign parityEven  = ctlReg[10];
  assign twoStop     = ctlReg[11];
  assign handshakeEn = ctlReg[12];
  assign forceBreak  = ctlReg[13];
  assign rdyDelay    = ctlReg[21:14];
  assign txThresh    = ctlReg[25:22];
  assign baudMant    = baudReg[11:0];
  assign baudExp     = baudReg[15:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlReg  <= '0;
      baudReg <= '0;
    end else if (wrEn) begin
      if (regAddr == RegCtrl) ctlReg  <= wrData[25:0];
      if (regAddr == RegBaud) baudReg <= wrData[15:0];
    end
  end

  // datapath strobes
  always_comb begin
    cmd.rxPull  = actWr & wrData[10];
    cmd.rxClear = actWr & wrData[11];
    cmd.txClear = actWr & wrData[12];
    cmd.txPush  = wrEn && regAddr == RegData;
  end

  // receive-ready delay timer
  assign rdyFire = dlyActive && (dlyCnt >= rdyDelay);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlyActive <= 1'b0;
      dlyCnt    <= '0;
    end else if (cmd.rxClear) begin
      dlyActive <= 1'b0;
    end else if (rxPushEmpty) begin
      dlyActive <= 1'b1;
      dlyCnt    <= '0;
    end else if (rdyFire) begin
      dlyActive <= 1'b0;
    end else if (dlyActive && bitTick) begin
      dlyCnt <= dlyCnt + 1'b1;
    end
  end

  assign txBelow = (txCount <= CW'(txThresh));

  // action bits remapped into status order
  always_comb begin
    clrV = '0;
    setV = '0;
    if (actWr) begin
      clrV[FL_RRDY] = wrData[0];  setV[FL_RRDY] = wrData[5];
      clrV[FL_OE]   = wrData[1];  setV[FL_OE]   = wrData[6];
      clrV[FL_BRK]  = wrData[2];  setV[FL_BRK]  = wrData[7];
      clrV[FL_FE]   = wrData[3];  setV[FL_FE]   = wrData[8];
      clrV[FL_PE]   = wrData[4];  setV[FL_PE]   = wrData[9];
      clrV[FL_TRDY] = wrData[13]; setV[FL_TRDY] = wrData[14];
    end
    hwSet          = '0;
    hwSet[FL_RRDY] = rdyFire;
    hwSet[FL_TRDY] = txBelow;
    hwSet[FL_OE]   = rxDrop;
    hwSet[FL_BRK]  = rxBreak;
    hwSet[FL_FE]   = rxStrobe & rxFrameErr;
    hwSet[FL_PE]   = rxStrobe & rxParityErr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clrV) | setV | hwSet;
  end

  always_comb begin
    enV          = '0;
    enV[FL_RRDY] = ctlReg[0];
    enV[FL_OE]   = ctlReg[1];
    enV[FL_BRK]  = ctlReg[2];
    enV[FL_FE]   = ctlReg[3];
    enV[FL_PE]   = ctlReg[4];
    enV[FL_TRDY] = ctlReg[5];
  end
  assign irq = |(flags & enV);

  always_comb begin
    case (regAddr)
      RegData:   rdData = 32'(rxData);
      RegCtrl:   rdData = {6'b0, ctlReg};
      RegBaud:   rdData = {16'b0, baudReg};
      RegStatus: rdData = {16'b0, 5'(txCount), 5'(rxCount), flags};
      default:   rdData = '0;
    endcase
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    actWr && wrData[5] |=> flags[FL_RRDY]); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    actWr && wrData[2] && !wrData[7] && !rxBreak |=> !flags[FL_BRK]); // R8
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rxDrop |=> flags[FL_OE]); // R6
  AST_TRDY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    txCount <= CW'(txThresh) |=> flags[FL_TRDY]); // R11
  AST_RRDY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    rdyFire && !cmd.rxClear |=> flags[FL_RRDY]); // R9
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              rxStrobe,
  input  logic [DATA_W-1:0] rxChar,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  input  logic              rxBreak,
  input  logic              bitTick,
  input  logic              txTake,
  output logic [DATA_W-1:0] txChar,
  output logic              txValid,
  input  logic              txSerialIn,
  output logic              txSerialOut,
  output logic [2:0]        wordLen,
  output logic              parityEn,
  output logic              parityEven,
  output logic              twoStop,
  output logic              handshakeEn,
  output logic [11:0]       baudMant,
  output logic [3:0]        baudExp,
  output logic              irq
);
  dpCmd_t cmd;
  logic [CW-1:0] rxCount, txCount;
  logic [DATA_W-1:0] rxData;
  logic rxPushEmpty, rxDrop, forceBreak;

  uart_regif_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .rxStrobe(rxStrobe),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr), .rxBreak(rxBreak),
    .bitTick(bitTick), .rxPushEmpty(rxPushEmpty), .rxDrop(rxDrop),
    .rxCount(rxCount), .txCount(txCount), .rxData(rxData), .cmd(cmd),
    .wordLen(wordLen), .parityEn(parityEn), .parityEven(parityEven),
    .twoStop(twoStop), .handshakeEn(handshakeEn), .forceBreak(forceBreak),
    .baudMant(baudMant), .baudExp(baudExp), .irq(irq));

  uart_regif_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .txWrData(wrData[DATA_W-1:0]),
    .rxStrobe(rxStrobe), .rxChar(rxChar), .txTake(txTake),
    .rxCount(rxCount), .txCount(txCount), .rxData(rxData),
    .rxPushEmpty(rxPushEmpty), .rxDrop(rxDrop), .txChar(txChar),
    .txValid(txValid));

  assign txSerialOut = forceBreak ? 1'b0 : txSerialIn;

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    forceBreak |-> !txSerialOut); // R3
endmodule

// File: tb/uart_regif_bench.sv
module uart_regif_bench;
  logic clk = 0, rst_n = 0;
  logic wrEn = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] wrData = 0, rdData;
  logic rxStrobe = 0, rxFrameErr = 0, rxParityErr = 0, rxBreak = 0, bitTick = 0;
  logic [7:0] rxChar = 0, txChar;
  logic txTake = 0, txValid, txSerialIn = 1, txSerialOut;
  logic [2:0] wordLen;
  logic parityEn, parityEven, twoStop, handshakeEn, irq;
  logic [11:0] baudMant;
  logic [3:0] baudExp;

  int nChk = 0, nBad = 0;
  bit done = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  uart_regif u_uart_regif (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .rxStrobe(rxStrobe), .rxChar(rxChar),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr), .rxBreak(rxBreak),
    .bitTick(bitTick), .txTake(txTake), .txChar(txChar), .txValid(txValid),
    .txSerialIn(txSerialIn), .txSerialOut(txSerialOut), .wordLen(wordLen),
    .parityEn(parityEn), .parityEven(parityEven), .twoStop(twoStop),
    .handshakeEn(handshakeEn), .baudMant(baudMant), .baudExp(baudExp), .irq(irq));

  // {word index, write value, expected read-back}
  localparam logic [66:0] VEC [6] = '{
    {3'd1, 32'hFFFF_FFFF, 32'h03FF_FFFF},
    {3'd2, 32'hDEAD_BEEF, 32'h0000_BEEF},
    {3'd1, 32'h0123_4567, 32'h0123_4567},
    {3'd3, 32'h0000_0000, 32'h0000_0000},
    {3'd5, 32'h0000_1234, 32'h0000_0000},
    {3'd2, 32'h0000_A5C3, 32'h0000_A5C3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrData = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic pushRx(input logic [7:0] c, input logic fe, input logic pe);
    @(negedge clk);
    rxStrobe = 1; rxChar = c; rxFrameErr = fe; rxParityErr = pe;
    @(negedge clk);
    rxStrobe = 0; rxFrameErr = 0; rxParityErr = 0;
  endtask

  task automatic tick();
    @(negedge clk); bitTick = 1;
    @(negedge clk); bitTick = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    // R14 reset state
    step(3);
    rd(4, v); chk("R14 status in reset", v, 0);
    rd(0, v); chk("R14 data in reset", v, 0);
    rd(1, v); chk("R14 control in reset", v, 0);
    rd(2, v); chk("R14 baud in reset", v, 0);
    chk("R14 irq in reset", 32'(irq), 0);
    rst_n = 1;
    step(1);
    rd(4, v); chk("R14 trdy after reset", v, 32'h2);

    // R1 register decode table
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][66:64], v);
      chk($sformatf("R1 vector %0d", i), v, VEC[i][31:0]);
    end

    // R2 configuration fields
    wr(1, 32'h0000_1B40);
    wr(2, 32'h0000_7ABC);
    chk("R2 wordLen", 32'(wordLen), 5);
    chk("R2 parity", {30'b0, parityEn, parityEven}, 32'h2);
    chk("R2 stop/handshake", {30'b0, twoStop, handshakeEn}, 32'h3);
    chk("R2 baud", {16'b0, baudExp, baudMant}, 32'h7ABC);

    // R3 force break
    txSerialIn = 1; #1;
    chk("R3 passthrough", 32'(txSerialOut), 1);
    wr(1, 32'h0000_3B40); #1;
    chk("R3 break low", 32'(txSerialOut), 0);
    wr(1, 32'h0000_1B40); #1;
    chk("R3 released", 32'(txSerialOut), 1);

    // R9 receive-ready delay of 3 bit times
    wr(1, 32'h0000_C000);
    pushRx(8'h41, 0, 0);
    step(3);
    rd(4, v); chk("R9 no ticks", 32'(v[0]), 0);
    tick(); tick(); step(1);
    rd(4, v); chk("R9 two ticks", 32'(v[0]), 0);
    tick(); step(1);
    rd(4, v); chk("R9 three ticks", 32'(v[0]), 1);

    // R4 ordering and pull
    pushRx(8'h42, 0, 0);
    pushRx(8'h43, 0, 0);
    rd(4, v); chk("R4 rx count", 32'(v[10:6]), 3);
    wr(3, 32'h400); rd(0, v); chk("R4 first pull", v, 32'h41);
    wr(3, 32'h400); rd(0, v); chk("R4 second pull", v, 32'h42);
    wr(3, 32'h400); rd(0, v); chk("R4 third pull", v, 32'h43);
    // R5 pull on empty
    wr(3, 32'h400); rd(0, v); chk("R5 empty pull data", v, 32'h43);
    rd(4, v); chk("R5 empty pull count", 32'(v[10:6]), 0);

    // R8 set and clear
    wr(3, 32'h1); rd(4, v); chk("R8 clear rrdy", 32'(v[0]), 0);
    wr(3, 32'h3FF); rd(4, v); chk("R8 set wins", 32'(v[5:0]), 32'h3F);
    wr(3, 32'h1F); rd(4, v); chk("R8 clear all", 32'(v[5:0]), 32'h02);

    // R7 error flags
    pushRx(8'h10, 1, 0);
    rd(4, v); chk("R7 framing", 32'(v[5:3]), 32'h2);
    pushRx(8'h11, 0, 1);
    rd(4, v); chk("R7 parity", 32'(v[5:3]), 32'h6);
    @(negedge clk); rxBreak = 1; @(negedge clk); rxBreak = 0;
    rd(4, v); chk("R7 break", 32'(v[5:3]), 32'h7);
    step(2);
    rd(4, v); chk("R7 sticky", 32'(v[5:3]), 32'h7);
    // R12 receive clear
    wr(3, 32'h800); rd(4, v); chk("R12 rx cleared", 32'(v[10:6]), 0);
    wr(3, 32'h1F);

    // R6 overrun
    for (int i = 0; i < 16; i++) pushRx(8'(i), 0, 0);
    rd(4, v); chk("R6 full no oe", {26'b0, v[10:6], v[2]}, {26'b0, 5'd16, 1'b0});
    pushRx(8'hEE, 0, 0);
    rd(4, v); chk("R6 overrun", {26'b0, v[10:6], v[2]}, {26'b0, 5'd16, 1'b1});
    for (int i = 0; i < 16; i++) wr(3, 32'h400);
    rd(0, v); chk("R6 extra dropped", v, 32'h0F);
    rd(4, v); chk("R6 drained", 32'(v[10:6]), 0);

    // R10 / R11 transmit path, threshold 2
    wr(3, 32'h1F);
    wr(1, 32'h0080_0000);
    rd(4, v); chk("R11 trdy empty", 32'(v[1]), 1);
    wr(0, 32'h55); wr(0, 32'h66); wr(0, 32'h77);
    rd(4, v); chk("R10 tx count", 32'(v[15:11]), 3);
    chk("R10 head", {23'b0, txValid, txChar}, 32'h155);
    wr(3, 32'h2000); rd(4, v); chk("R11 clear above thr", 32'(v[1]), 0);
    wr(3, 32'h4000); rd(4, v); chk("R11 set", 32'(v[1]), 1);
    wr(3, 32'h2000);
    @(negedge clk); txTake = 1; @(negedge clk); txTake = 0;
    chk("R10 take", {23'b0, txValid, txChar}, 32'h166);
    step(1);
    rd(4, v); chk("R11 at thr", {26'b0, v[15:11], v[1]}, {26'b0, 5'd2, 1'b1});
    for (int i = 0; i < 14; i++) wr(0, 32'(i));
    wr(0, 32'h99);
    rd(4, v); chk("R10 full drop", 32'(v[15:11]), 16);
    wr(3, 32'h1000);
    rd(4, v); chk("R12 tx cleared", {26'b0, v[15:11], txValid}, 0);

    // R13 interrupt
    wr(3, 32'h1F);
    wr(1, 32'h20); chk("R13 trdy enabled", 32'(irq), 1);
    wr(1, 32'h02); chk("R13 oe masked off", 32'(irq), 0);
    wr(3, 32'h40); chk("R13 oe raises", 32'(irq), 1);
    wr(1, 32'h0);  chk("R13 all disabled", 32'(irq), 0);

    finishRun();
  end
endmodule